// File: doc/BRIEF.md
# Per-Bank Attack Alert Register

This block sits on the DRAM rank side and keeps a record of which banks have been flagged as targets of a row-hammering attack. Each bank owns one alert bit. A detector outside the block (activation counting or any other rule) delivers a one-clock pulse on the bank's flag input, and the bit latches. While any bit is set, the block raises a back-off alert toward the memory controller.

The controller answers the alert by issuing a mask-request strobe. On the next clock the block returns the whole bit vector on a response bus, qualified by a one-clock valid strobe. At the same time it clears exactly the bits it reported. The controller can then direct its mitigation commands at the flagged banks only. A flag that arrives in the same clock as the clear is kept, so no attack report is lost between two requests.

Top module: `bank_alert_reg`

## Requirements
- R1: Bank `i` maps to bit `i` of both `hit_pulse` and `resp_data`, for `i` from 0 to `NUM_BANKS-1`.
- R2: A high `hit_pulse[i]` in a clock sets bank `i`'s alert bit at that clock edge; the bits of other banks are not changed.
- R3: `alert` is the OR of all alert bits delayed by one register. A flag in cycle k raises `alert` in cycle k+2, and `alert` falls one cycle after the last bit clears.
- R4: When `mask_req` is high in cycle k, `resp_vld` is high in cycle k+1 only, and `resp_data` in cycle k+1 equals the alert bits held during cycle k.
- R5: `resp_data` is all zeros in every cycle where `resp_vld` is low.
- R6: The bits that are reported are cleared at the same clock edge that loads the response. Without a request, no bit is ever cleared.
- R7: A `hit_pulse[i]` in the same cycle as `mask_req` leaves bit `i` set after the edge, and the next request reports it.
- R8: A flag for a bank whose bit is already set has no further effect: the bank is reported once, and one request clears it.
- R9: Synchronous active-low reset clears every alert bit and drives `alert`, `resp_vld` and `resp_data` low. Reset overrides a flag pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_pulse | input | NUM_BANKS | One-clock attack flag per bank, bit i is bank i |
| mask_req | input | 1 | Controller request to read and clear the alert vector |
| alert | output | 1 | Back-off alert, high while any bank bit is set (one clock of delay) |
| resp_vld | output | 1 | One-clock strobe qualifying `resp_data` |
| resp_data | output | NUM_BANKS | Reported alert vector, zero when not valid |

## Verification
The bench targets a flag arriving in the same clock as a request. A design that lets the clear win there would silently drop that bank's report, and the following request would read zero. It also repeats flags on a bank that is already set, to catch a design that toggles the bit or needs two requests to clear it. It issues back-to-back and empty requests, where an off-by-one response stage would return stale or non-zero data. It walks a single flag across every bank, to expose swapped or shifted bit positions. Finally, it asserts reset together with a flag, where a wrong priority would leave a bit alive after reset.

// File: rtl/bank_alert_pkg.sv
// Package: shared defaults and helpers for the per-bank alert register.
// Assumes: nothing beyond standard integer arithmetic.
package bank_alert_pkg;

    localparam int unsigned BANKS_DEFAULT = 16;
    localparam int unsigned OR_FANIN_DEFAULT = 4;

    // Number of fan-in groups needed to cover n inputs.
    function automatic int unsigned group_count(input int unsigned n, input int unsigned fanin);
        return (n + fanin - 1) / fanin;
    endfunction

endpackage

// File: rtl/bank_alert_cell.sv
// Module: bank_alert_cell
// Holds one bank's alert bit. A flag sets it. A clear drops it, but a flag
// in the same cycle wins. Assumes clr is asserted only when the bit's
// value is being reported, so clearing the bit equals clearing what was reported.
module bank_alert_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    // Update the bit: reset first, then set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/alert_or_tree.sv
// Module: alert_or_tree
// Reduces N bits to one through a two-level OR of FANIN-wide groups,
// then registers the result. Assumes FANIN >= 1.
module alert_or_tree
    import bank_alert_pkg::*;
#(
    parameter int unsigned N     = BANKS_DEFAULT,
    parameter int unsigned FANIN = OR_FANIN_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bits,
    output logic         any_q
);

    localparam int unsigned GROUPS = group_count(N, FANIN);
    localparam int unsigned PADDED = GROUPS * FANIN;

    logic [PADDED-1:0] padded;
    logic [GROUPS-1:0] group_or;
    logic              any_comb;

    generate
        if (PADDED > N) begin : g_pad
            assign padded = {{(PADDED - N){1'b0}}, bits};
        end else begin : g_nopad
            assign padded = bits;
        end

        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign group_or[g] = |padded[g*FANIN +: FANIN];
        end
    endgenerate

    assign any_comb = |group_or;

    // Register the reduced alert so the output leaves the block from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            any_q <= 1'b0;
        else
            any_q <= any_comb;
    end

endmodule

// File: rtl/mask_response.sv
// Module: mask_response
// On a request, captures the alert vector into the response register for
// one clock with a valid strobe. Data reads zero while valid is low.
// Assumes bits is the register contents before the clearing edge.
module mask_response #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [N-1:0] bits,
    output logic         vld,
    output logic [N-1:0] data
);

    // Load or zero the response each clock, qualified by the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else if (req) begin
            vld  <= 1'b1;
            data <= bits;
        end else begin
            vld  <= 1'b0;
            data <= '0;
        end
    end

endmodule

// File: rtl/bank_alert_reg.sv
// Module: bank_alert_reg (top)
// Collects per-bank attack flags into a vector. Raises a back-off alert
// while any bit is set. Returns and clears the vector on a mask request.
// Assumes hit_pulse and mask_req are synchronous to clk.
module bank_alert_reg
    import bank_alert_pkg::*;
#(
    parameter int unsigned NUM_BANKS = BANKS_DEFAULT,
    parameter int unsigned OR_FANIN  = OR_FANIN_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] hit_pulse,
    input  logic                 mask_req,
    output logic                 alert,
    output logic                 resp_vld,
    output logic [NUM_BANKS-1:0] resp_data
);

    logic [NUM_BANKS-1:0] alert_bits;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bank_alert_cell u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .hit  (hit_pulse[b]),
                .clr  (mask_req),
                .flag (alert_bits[b])
            );
        end
    endgenerate

    alert_or_tree #(
        .N    (NUM_BANKS),
        .FANIN(OR_FANIN)
    ) u_or (
        .clk  (clk),
        .rst_n(rst_n),
        .bits (alert_bits),
        .any_q(alert)
    );

    mask_response #(
        .N(NUM_BANKS)
    ) u_resp (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (mask_req),
        .bits (alert_bits),
        .vld  (resp_vld),
        .data (resp_data)
    );

endmodule

// File: rtl/bank_alert_chk.sv
// Module: bank_alert_chk
// Property checker for bank_alert_reg, attached by bind below.
// Assumes it sees the top's ports and its internal alert vector.
module bank_alert_chk #(
    parameter int unsigned NUM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] hit_pulse,
    input logic                 mask_req,
    input logic [NUM_BANKS-1:0] alert_bits,
    input logic                 alert,
    input logic                 resp_vld,
    input logic [NUM_BANKS-1:0] resp_data
);

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pulse != '0) |=> ((alert_bits & $past(hit_pulse)) == $past(hit_pulse))); // R2

    AST_ALERT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_bits != '0) |=> alert); // R3

    AST_ALERT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_bits == '0) |=> !alert); // R3

    AST_RESP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_req |=> (resp_vld && resp_data == $past(alert_bits))); // R4

    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_req |=> !resp_vld); // R4

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_vld |-> (resp_data == '0)); // R5

    AST_CLEAR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        mask_req |=> (alert_bits == $past(hit_pulse))); // R6

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_req |=> (alert_bits == ($past(alert_bits) | $past(hit_pulse)))); // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (alert_bits == '0 && !alert && !resp_vld)); // R9

endmodule

bind bank_alert_reg bank_alert_chk #(
    .NUM_BANKS(NUM_BANKS)
) u_bank_alert_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_pulse (hit_pulse),
    .mask_req  (mask_req),
    .alert_bits(alert_bits),
    .alert     (alert),
    .resp_vld  (resp_vld),
    .resp_data (resp_data)
);

// File: tb/test_bank_alert_reg.sv
module test_bank_alert_reg;

    localparam int NB = 16;
    localparam int NVEC = 14;

    // Per step: hit, req, expected vld, expected data, expected alert (after edge).
    typedef struct packed {
        logic [NB-1:0] hit;
        logic          req;
        logic          vld;
        logic [NB-1:0] data;
        logic          alert;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h0001, 1'b0, 1'b0, 16'h0000, 1'b0},  // R2 set bank 0
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},  // R3 alert two cycles after flag
        '{16'h0000, 1'b1, 1'b1, 16'h0001, 1'b1},  // R4 report bank 0
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},  // R6 cleared, alert falls
        '{16'h8000, 1'b0, 1'b0, 16'h0000, 1'b0},  // R1 top bank
        '{16'h0010, 1'b0, 1'b0, 16'h0000, 1'b1},  // R2 second bank
        '{16'h0010, 1'b0, 1'b0, 16'h0000, 1'b1},  // R8 repeat flag
        '{16'h0400, 1'b1, 1'b1, 16'h8010, 1'b1},  // R7 flag meets request
        '{16'h0000, 1'b1, 1'b1, 16'h0400, 1'b1},  // R7 kept flag reported next
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},  // R5 idle zero
        '{16'h0000, 1'b1, 1'b1, 16'h0000, 1'b0},  // R4 empty request
        '{16'hFFFF, 1'b0, 1'b0, 16'h0000, 1'b0},  // R2 all banks
        '{16'h0000, 1'b1, 1'b1, 16'hFFFF, 1'b1},  // R4 full report
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0}   // R6 all cleared
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] hit_pulse = '0;
    logic          mask_req = 1'b0;
    logic          alert;
    logic          resp_vld;
    logic [NB-1:0] resp_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    bank_alert_reg #(.NUM_BANKS(NB)) i_bank_alert_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_pulse(hit_pulse),
        .mask_req (mask_req),
        .alert    (alert),
        .resp_vld (resp_vld),
        .resp_data(resp_data)
    );

    task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic [NB-1:0] h, input logic r);
        @(negedge clk);
        hit_pulse = h;
        mask_req  = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        // R9 reset state
        step('0, 1'b0);
        step('0, 1'b0);
        check("R9 alert", {15'b0, alert}, '0);
        check("R9 vld", {15'b0, resp_vld}, '0);
        check("R9 data", resp_data, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VECS[i].hit, VECS[i].req);
            check($sformatf("R4 vec%0d vld", i), {15'b0, resp_vld}, {15'b0, VECS[i].vld});
            check($sformatf("R5 vec%0d data", i), resp_data, VECS[i].data);
            check($sformatf("R3 vec%0d alert", i), {15'b0, alert}, {15'b0, VECS[i].alert});
        end

        // R1 walking flag: each bank lands on its own bit
        for (int b = 0; b < NB; b++) begin
            step(NB'(1) << b, 1'b0);
            step('0, 1'b1);
            check($sformatf("R1 bank%0d", b), resp_data, NB'(1) << b);
        end
        step('0, 1'b0);

        // R8 repeated flags: reported once, one request clears
        step(16'h0200, 1'b0);
        step(16'h0200, 1'b0);
        step(16'h0200, 1'b0);
        step('0, 1'b1);
        check("R8 single report", resp_data, 16'h0200);
        step('0, 1'b1);
        check("R8 cleared once", resp_data, '0);

        // R9 reset mid-run with a flag in the same cycle
        step(16'h0033, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        hit_pulse = 16'h0100;
        @(posedge clk);
        #1;
        check("R9 vld in reset", {15'b0, resp_vld}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        hit_pulse = '0;
        step('0, 1'b1);
        check("R9 bits cleared", resp_data, '0);
        step('0, 1'b0);
        check("R9 alert low", {15'b0, alert}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule